// File: doc/BRIEF.md
# Pulsed Burst Sample Gate

This block sits between a receive front end and a packet engine. Both run on one 100 MHz clock. A free-running counter divides time into repetition periods. During the first few counts of each period the block passes samples on to the packet engine; for the rest of the period its valid strobe stays low. The first word of every burst is replaced by a tag. The tag holds a 16-bit pulse sequence number and the state of 16 digital input pins, so the receiving side can line up bursts with external events.

There are two sources of sample. In full-rate mode the block packs the upper 16 bits of each 24-bit I and Q front-end sample and releases a word on every clock inside the window. In decimated mode it forwards the already-packed decimated-path word, and only on clocks where that path's strobe is high. The period length and the burst length are write-only registers on a small addressed settings bus. They can be loaded whether or not the gate is enabled.

Top module: `burst_gate`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `bb_strobe` is 0 and `bb_sample` is 0. The period register resets to `DEF_PERIOD` (16) and the burst-length register resets to `DEF_WIDTH` (4).
- R2: In full-rate mode (`mode_decim` = 0) at a nonzero count, the output word is `{fe_i[23:8], fe_q[23:8]}`, with I in bits 31:16 and Q in bits 15:0. The word and `bb_strobe` are registered together: both show the inputs sampled at the previous rising edge.
- R3: The position counter steps 0, 1, … P-1 and then returns to 0, where P is the period register. A P of 0 or 1 gives a one-cycle period, so the count stays at 0. If P is lowered below the current count, the counter returns to 0 at the next edge.
- R4: In full-rate mode, `bb_strobe` is high exactly when the count is below the burst length N. If N is 0, no strobe is ever produced. If N is at least P, the strobe is high on every cycle of the period.
- R5: While `enable` is low, `bb_strobe` is 0, and the counter and the sequence number are held at 0. The first word after `enable` rises is therefore a tag carrying sequence number 0.
- R6: At count 0 the output word is `{seq, gpio_in}`, with the sequence number in bits 31:16 and the pins in bits 15:0. The sequence number rises by one each time the counter wraps to 0, and it rolls over from 16'hFFFF to 0.
- R7: In decimated mode (`mode_decim` = 1), `bb_strobe` is high only when `ddc_strobe` was high and the count was inside the window. At nonzero counts the word is `ddc_sample` unchanged.
- R8: A settings write is one cycle with `set_stb` high. Address `PERIOD_ADDR` (default 0) loads P and address `WIDTH_ADDR` (default 1) loads N. The new value governs the counter and window from the second rising edge after the edge that samples the write, and this holds regardless of `enable`. Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz clock for all logic |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Gate enable; low clears counter and sequence number |
| mode_decim | input | 1 | 0 = full-rate front-end samples, 1 = decimated-path samples |
| fe_i | input | 24 | Front-end I sample, new every clock |
| fe_q | input | 24 | Front-end Q sample, new every clock |
| ddc_sample | input | 32 | Decimated-path packed word (I high, Q low) |
| ddc_strobe | input | 1 | Decimated-path valid pulse |
| gpio_in | input | 16 | Digital input pins captured into the tag word |
| set_stb | input | 1 | Settings write strobe |
| set_addr | input | 8 | Settings write address |
| set_data | input | 32 | Settings write data |
| bb_sample | output | 32 | Packed output word to packet engine |
| bb_strobe | output | 1 | Output word valid |

## Verification
The word and strobe are due one rising edge after the inputs that produce them. A settings write takes effect at the counter and window two edges after the edge that samples it. So the first output that shows a new period or burst length appears one edge after that. The bench runs a behavioural model that advances at each rising edge on the inputs held since the last falling edge. It compares both outputs at the following falling edge. Stimulus is changed only at that falling edge, so every expected value lines up with the register stage that produces it.

// File: rtl/burst_gate_pkg.sv
package burst_gate_pkg;

    localparam int FE_W   = 24;  // front-end sample width
    localparam int HALF_W = 16;  // one output component
    localparam int BB_W   = 2 * HALF_W;
    localparam int CFG_W  = 32;  // settings data and counter width
    localparam int ADDR_W = 8;
    localparam int GPIO_W = 16;

    // one settings register: captured write, change flag, live copy
    typedef struct packed {
        logic [CFG_W-1:0] shadow;
        logic             changed;
        logic [CFG_W-1:0] value;
    } setreg_t;

    // period position and burst sequence number
    typedef struct packed {
        logic [CFG_W-1:0]  count;
        logic [HALF_W-1:0] seq;
    } pcnt_t;

    // registered output pair
    typedef struct packed {
        logic [BB_W-1:0] word;
        logic            valid;
    } bbout_t;

endpackage

// File: rtl/bg_setting_reg.sv
module bg_setting_reg
    import burst_gate_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ADDR      = '0,
    parameter logic [CFG_W-1:0]  RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_stb,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [CFG_W-1:0]  set_data,
    output logic [CFG_W-1:0]  value
);

    setreg_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.changed = set_stb && (set_addr == ADDR);
        if (r_d.changed) begin
            r_d.shadow = set_data;
        end
        // live copy follows the captured value one edge after the write
        if (r_q.changed) begin
            r_d.value = r_q.shadow;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{shadow: RESET_VAL, changed: 1'b0, value: RESET_VAL};
        end else begin
            r_q <= r_d;
        end
    end

    assign value = r_q.value;

endmodule

// File: rtl/bg_period_counter.sv
module bg_period_counter
    import burst_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [CFG_W-1:0]  period,
    output logic [CFG_W-1:0]  count,
    output logic [HALF_W-1:0] seq
);

    pcnt_t            c_d, c_q;
    logic [CFG_W-1:0] last_idx;

    // periods of 0 and 1 both collapse to a single-cycle period
    assign last_idx = (period == '0) ? '0 : period - 1'b1;

    always_comb begin
        c_d = c_q;
        if (!enable) begin
            c_d.count = '0;
            c_d.seq   = '0;
        end else if (c_q.count >= last_idx) begin
            c_d.count = '0;
            c_d.seq   = c_q.seq + 1'b1;
        end else begin
            c_d.count = c_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count = c_q.count;
    assign seq   = c_q.seq;

endmodule

// File: rtl/bg_sample_former.sv
module bg_sample_former
    import burst_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              mode_decim,
    input  logic [CFG_W-1:0]  count,
    input  logic [HALF_W-1:0] seq,
    input  logic [CFG_W-1:0]  width,
    input  logic [FE_W-1:0]   fe_i,
    input  logic [FE_W-1:0]   fe_q,
    input  logic [BB_W-1:0]   ddc_sample,
    input  logic              ddc_strobe,
    input  logic [GPIO_W-1:0] gpio_in,
    output logic [BB_W-1:0]   bb_sample,
    output logic              bb_strobe
);

    bbout_t o_d, o_q;
    logic   in_window;
    logic   at_start;
    logic   src_ok;

    assign in_window = count < width;
    assign at_start  = count == '0;
    assign src_ok    = !mode_decim || ddc_strobe;

    always_comb begin
        o_d       = o_q;
        o_d.valid = enable && in_window && src_ok;
        if (at_start) begin
            o_d.word = {seq, gpio_in};
        end else if (mode_decim) begin
            o_d.word = ddc_sample;
        end else begin
            o_d.word = {fe_i[FE_W-1 -: HALF_W], fe_q[FE_W-1 -: HALF_W]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign bb_sample = o_q.word;
    assign bb_strobe = o_q.valid;

endmodule

// File: rtl/burst_gate.sv
module burst_gate
    import burst_gate_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PERIOD_ADDR = 8'd0,
    parameter logic [ADDR_W-1:0] WIDTH_ADDR  = 8'd1,
    parameter logic [CFG_W-1:0]  DEF_PERIOD  = 32'd16,
    parameter logic [CFG_W-1:0]  DEF_WIDTH   = 32'd4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        mode_decim,
    input  logic [23:0] fe_i,
    input  logic [23:0] fe_q,
    input  logic [31:0] ddc_sample,
    input  logic        ddc_strobe,
    input  logic [15:0] gpio_in,
    input  logic        set_stb,
    input  logic [7:0]  set_addr,
    input  logic [31:0] set_data,
    output logic [31:0] bb_sample,
    output logic        bb_strobe
);

    localparam int NUM_REGS = 2;
    localparam int IDX_PER  = 0;
    localparam int IDX_WID  = 1;
    localparam logic [NUM_REGS-1:0][ADDR_W-1:0] REG_ADDR  = {WIDTH_ADDR, PERIOD_ADDR};
    localparam logic [NUM_REGS-1:0][CFG_W-1:0]  REG_RESET = {DEF_WIDTH, DEF_PERIOD};

    logic [NUM_REGS-1:0][CFG_W-1:0] reg_val;
    logic [CFG_W-1:0]               period_val;
    logic [CFG_W-1:0]               width_val;
    logic [CFG_W-1:0]               cnt_val;
    logic [HALF_W-1:0]              seq_val;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cfg
        bg_setting_reg #(
            .ADDR      (REG_ADDR[g]),
            .RESET_VAL (REG_RESET[g])
        ) u_reg (
            .clk      (clk),
            .rst      (rst),
            .set_stb  (set_stb),
            .set_addr (set_addr),
            .set_data (set_data),
            .value    (reg_val[g])
        );
    end

    assign period_val = reg_val[IDX_PER];
    assign width_val  = reg_val[IDX_WID];

    bg_period_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .period (period_val),
        .count  (cnt_val),
        .seq    (seq_val)
    );

    bg_sample_former u_fmt (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .mode_decim (mode_decim),
        .count      (cnt_val),
        .seq        (seq_val),
        .width      (width_val),
        .fe_i       (fe_i),
        .fe_q       (fe_q),
        .ddc_sample (ddc_sample),
        .ddc_strobe (ddc_strobe),
        .gpio_in    (gpio_in),
        .bb_sample  (bb_sample),
        .bb_strobe  (bb_strobe)
    );

endmodule

// File: rtl/bg_checker.sv
module bg_checker (
    input logic        clk,
    input logic        rst,
    input logic        enable,
    input logic        mode_decim,
    input logic        ddc_strobe,
    input logic        bb_strobe,
    input logic [31:0] bb_sample,
    input logic [31:0] count,
    input logic [15:0] seq,
    input logic [31:0] period,
    input logic [31:0] width
);

    // R1: reset leaves the output pair cleared
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!bb_strobe && bb_sample == '0));

    // R5: no strobe follows a disabled cycle
    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !$past(enable) |-> !bb_strobe);

    // R4: a zero burst length yields no strobe
    a_r4_zero_width_silent: assert property (@(posedge clk) disable iff (rst)
        ($past(width) == '0) |-> !bb_strobe);

    // R3: a count at or past the period returns to zero next
    a_r3_wrap_in_range: assert property (@(posedge clk) disable iff (rst)
        (count >= period) |=> (count == '0));

    // R6: while enabled the sequence only steps by one, on a wrap
    a_r6_seq_steps: assert property (@(posedge clk) disable iff (rst)
        ($past(enable) && !$stable(seq)) |-> (seq == $past(seq) + 16'd1 && count == '0));

    // R7: decimated mode never strobes without a decimated pulse
    a_r7_decim_needs_pulse: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_decim) && !$past(ddc_strobe)) |-> !bb_strobe);

endmodule

bind burst_gate bg_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .mode_decim (mode_decim),
    .ddc_strobe (ddc_strobe),
    .bb_strobe  (bb_strobe),
    .bb_sample  (bb_sample),
    .count      (cnt_val),
    .seq        (seq_val),
    .period     (period_val),
    .width      (width_val)
);

// File: tb/burst_gate_tb.sv
module burst_gate_tb;

    localparam logic [7:0]  PA    = 8'd0;
    localparam logic [7:0]  WA    = 8'd1;
    localparam int unsigned DEF_P = 16;
    localparam int unsigned DEF_W = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        mode_decim = 1'b0;
    logic [23:0] fe_i = '0;
    logic [23:0] fe_q = '0;
    logic [31:0] ddc_sample = '0;
    logic        ddc_strobe = 1'b0;
    logic [15:0] gpio_in = '0;
    logic        set_stb = 1'b0;
    logic [7:0]  set_addr = '0;
    logic [31:0] set_data = '0;
    logic [31:0] bb_sample;
    logic        bb_strobe;

    always #5 clk = ~clk;

    burst_gate u_dut (
        .clk(clk), .rst(rst), .enable(enable), .mode_decim(mode_decim),
        .fe_i(fe_i), .fe_q(fe_q), .ddc_sample(ddc_sample), .ddc_strobe(ddc_strobe),
        .gpio_in(gpio_in), .set_stb(set_stb), .set_addr(set_addr), .set_data(set_data),
        .bb_sample(bb_sample), .bb_strobe(bb_strobe)
    );

    // reference model state
    int unsigned m_cnt, m_seq, m_per, m_wid, sh_per, sh_wid, m_eff;
    bit          pend_per, pend_wid;
    logic [31:0] e_sample = '0;
    logic        e_strobe = 1'b0;
    string       e_req_s = "R1";
    string       e_req_w = "R1";

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int ddc_m = 0;
    int ddc_ph = 0;
    int strobe_cnt = 0;
    logic [15:0] prev_hi = '0;
    bit prev_tag = 0;
    bit seen_roll = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_seq = 0; m_per = DEF_P; m_wid = DEF_W;
            sh_per = DEF_P; sh_wid = DEF_W; pend_per = 0; pend_wid = 0;
            e_sample = '0; e_strobe = 1'b0; e_req_s = "R1"; e_req_w = "R1";
        end else begin
            e_strobe = enable && (m_cnt < m_wid) && (!mode_decim || ddc_strobe);
            if (m_cnt == 0)      e_sample = {m_seq[15:0], gpio_in};
            else if (mode_decim) e_sample = ddc_sample;
            else                 e_sample = {fe_i[23:8], fe_q[23:8]};
            e_req_s = !enable ? "R5" : (mode_decim ? "R7" : "R4");
            e_req_w = (m_cnt == 0) ? "R6" : (mode_decim ? "R7" : "R2");
            m_eff = (m_per == 0) ? 1 : m_per;
            if (!enable) begin
                m_cnt = 0; m_seq = 0;
            end else if (m_cnt + 1 >= m_eff) begin
                m_cnt = 0; m_seq = (m_seq + 1) % 65536;
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (pend_per) m_per = sh_per;
            if (pend_wid) m_wid = sh_wid;
            pend_per = set_stb && (set_addr == PA);
            pend_wid = set_stb && (set_addr == WA);
            if (pend_per) sh_per = set_data;
            if (pend_wid) sh_wid = set_data;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk(e_req_s, {31'd0, bb_strobe}, {31'd0, e_strobe});
            chk(e_req_w, bb_sample, e_sample);
            if (bb_strobe) strobe_cnt++;
            if (prev_tag && prev_hi == 16'hFFFF && bb_strobe && bb_sample[31:16] == 16'h0000)
                seen_roll = 1;
            prev_hi  = bb_sample[31:16];
            prev_tag = bb_strobe;
            fe_i       = 24'($urandom);
            fe_q       = 24'($urandom);
            gpio_in    = 16'($urandom);
            ddc_sample = $urandom;
            if (ddc_m > 0) begin
                ddc_ph     = (ddc_ph + 1) % ddc_m;
                ddc_strobe = (ddc_ph == 0);
            end else begin
                ddc_strobe = 1'b0;
            end
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        set_stb = 1'b1; set_addr = a; set_data = d;
        step(1);
        set_stb = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", {31'd0, bb_strobe}, 32'd0);
        chk("R1", bb_sample, 32'd0);
        rst = 1'b0;
        step(4);

        // full-rate default settings
        enable = 1'b1;
        step(1);
        chk("R5", {16'd0, bb_sample[31:16]}, 32'd0);
        step(100);

        // new period and width while running
        wr(PA, 32'd10);
        wr(WA, 32'd3);
        step(30);
        strobe_cnt = 0; step(20);
        chk("R4", strobe_cnt, 32'd6);

        // write to an unused address
        wr(8'd7, 32'd0);
        step(3);
        strobe_cnt = 0; step(20);
        chk("R8", strobe_cnt, 32'd6);

        // zero width, then width above the period
        wr(WA, 32'd0);
        step(3);
        strobe_cnt = 0; step(20);
        chk("R4", strobe_cnt, 32'd0);
        wr(WA, 32'd50);
        step(3);
        strobe_cnt = 0; step(20);
        chk("R4", strobe_cnt, 32'd20);

        // degenerate periods and a shrink below the count
        wr(PA, 32'd0);
        step(10);
        wr(PA, 32'd40);
        step(30);
        wr(PA, 32'd5);
        step(20);
        wr(PA, 32'd1);
        step(10);

        // settings written while disabled
        enable = 1'b0;
        step(3);
        wr(PA, 32'd6);
        wr(WA, 32'd2);
        step(3);
        chk("R5", {31'd0, bb_strobe}, 32'd0);
        enable = 1'b1;
        step(1);
        chk("R5", {15'd0, bb_strobe, bb_sample[31:16]}, 32'h0001_0000);
        step(11);
        strobe_cnt = 0; step(12);
        chk("R8", strobe_cnt, 32'd4);

        // enable toggling
        for (int r = 0; r < 6; r++) begin
            enable = 1'b0; step(1 + r);
            enable = 1'b1; step(3 + 2 * r);
        end

        // decimated mode
        mode_decim = 1'b1;
        ddc_m = 5;
        wr(PA, 32'd12);
        wr(WA, 32'd8);
        step(120);
        ddc_m = 3;
        step(60);
        mode_decim = 1'b0;
        ddc_m = 0;
        step(20);

        // sequence rollover with a one-cycle period
        wr(PA, 32'd1);
        wr(WA, 32'd1);
        step(65545);
        chk("R6", {31'd0, seen_roll}, 32'd1);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule